// File: doc/BRIEF.md
# Shared Memory Ownership Guard

This block sits in front of a bank of shared memory blocks that two CPU subsystems use, called side A and side B. Each side has a CPU requester and a DMA requester. Every block belongs to exactly one side at a time. A one-bit owner flag per block records which side that is. The guard inspects each access attempt and grants or refuses it. It bases the decision on who is asking, whether the access is a read, a write or an instruction fetch, and which side owns the addressed block. Granted accesses reach a plain behavioural memory. Refused accesses never touch it, and each one is reported on a violation strobe.

Software on the side A CPU hands blocks over by writing the owner vector, and it can take them back the same way. A write to the owner vector from any other requester is dropped and flagged. Requests arrive on a single request channel, one per cycle at most. Arbitration between requesters is handled outside this block.

Top module: `shram_guard`

## Requirements
- R1: After reset, `owner_map` is all zero, so side A owns every block. `rsp_valid`, `rd_valid`, `viol_valid` and `cfg_err` are low.
- R2: The CPU of the owning side is granted read (kind 0), write (kind 1) and fetch (kind 2) on that block. Requester ID encoding: 0 = CPU A, 1 = DMA A, 2 = CPU B, 3 = DMA B. ID bit 1 is the side and ID bit 0 marks a DMA.
- R3: The DMA of the owning side is granted read and write on that block, and its fetch is refused.
- R4: Both requesters of the non-owning side are granted reads only. Their writes and fetches are refused. Kind code 3 is reserved and is refused for every requester.
- R5: `owner_map` bit i set to 1 means side B owns block i. The vector changes only on a `cfg_we` cycle with `cfg_id` = 0. The new value applies to requests from the following cycle onward.
- R6: A `cfg_we` from any ID other than 0 leaves `owner_map` unchanged. It raises `cfg_err` for exactly the next cycle.
- R7: A refused write leaves the addressed word unchanged. A later granted read returns the earlier contents.
- R8: Each request sampled on a clock edge produces `rsp_valid` for exactly the following cycle. `rsp_grant` carries the decision. No response appears without a request.
- R9: A granted read or fetch returns the word on `rd_data` with `rd_valid` high one cycle after the response. Writes and refused accesses raise no `rd_valid`.
- R10: A refused access raises `viol_valid` in the response cycle, with `viol_id` holding the requester ID and `viol_blk` holding the block index. `viol_valid` is low otherwise.
- R11: Address bits `[ADDR_W-1:WRD_W]` pick the block and bits `[WRD_W-1:0]` pick the word inside it. The first and last word of every block are reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access attempt this cycle |
| req_id | input | 2 | Requester ID |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_addr | input | ADDR_W | Block index (upper bits) and word index (lower bits) |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_grant | output | 1 | Access was granted |
| viol_valid | output | 1 | Refused-access pulse |
| viol_id | output | 2 | Requester of the refused access |
| viol_blk | output | BLK_W | Block of the refused access |
| rd_valid | output | 1 | Read or fetch data strobe |
| rd_data | output | DW | Read or fetch data |
| cfg_we | input | 1 | Owner vector write attempt |
| cfg_id | input | 2 | Requester ID of the owner vector write |
| cfg_wdata | input | NBLK | New owner vector |
| cfg_err | output | 1 | Illegal owner vector write pulse |
| owner_map | output | NBLK | Current owner vector |

## Verification
The bench runs the access-rights matrix for every requester, first with side A owning everything and again after blocks have moved to side B. A guard that mixed up the owning CPU and DMA would let a DMA fetch go through or refuse a CPU fetch. A guard that forgot the non-owner's read right would refuse a read. Owner vector writes from the three non-CPU-A IDs are checked for both the dropped update and the error pulse. A guard that trusted any writer would change the grant pattern that follows. A refused write is followed by a read of the same word, which catches a memory written before the decision. Writes to the first and last words of the outermost blocks catch a swapped or shifted address split.

// File: rtl/shram_pkg.sv
package shram_pkg;

  // Access kind carried on req_kind
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Requester ID split: bit 1 = side (0 = A, 1 = B), bit 0 = DMA
  typedef struct packed {
    logic side;
    logic dma;
  } src_t;

  // The only requester allowed to program the owner vector
  localparam logic [1:0] ID_CPU_A = 2'd0;

endpackage

// File: rtl/shram_perm.sv
module shram_perm
  import shram_pkg::*;
(
  input  logic [1:0] kind,
  input  src_t       src,
  input  logic       owner,
  output logic       grant
);

  logic owns;

  always_comb begin
    owns  = (src.side == owner);
    grant = 1'b0;
    case (acc_e'(kind))
      ACC_READ:  grant = 1'b1;
      ACC_WRITE: grant = owns;
      ACC_FETCH: grant = owns && !src.dma;
      default:   grant = 1'b0;
    endcase
  end

endmodule

// File: rtl/shram_owner_reg.sv
module shram_owner_reg
  import shram_pkg::*;
#(
  parameter int NBLK = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_id,
  input  logic [NBLK-1:0] cfg_wdata,
  output logic [NBLK-1:0] owner_map,
  output logic            cfg_err
);

  logic cfg_ok;
  logic err_d;

  always_comb begin
    cfg_ok = cfg_we && (cfg_id == ID_CPU_A);
    err_d  = cfg_we && (cfg_id != ID_CPU_A);
  end

  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    logic own_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q <= 1'b0;
      end else if (cfg_ok) begin
        own_q <= cfg_wdata[b];
      end
    end
    assign owner_map[b] = own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= err_d;
    end
  end

endmodule

// File: rtl/shram_mem.sv
module shram_mem #(
  parameter  int NBLK  = 16,
  parameter  int WORDS = 8,
  parameter  int DW    = 16,
  localparam int BLK_W = $clog2(NBLK),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic [WRD_W-1:0] wr_word,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [WRD_W-1:0] rd_word,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] bank_q [NBLK];
  logic [DW-1:0] rd_d;

  for (genvar b = 0; b < NBLK; b++) begin : g_bank
    logic [DW-1:0] words [WORDS];
    logic          we_b;

    assign we_b = wr_en && (wr_blk == BLK_W'(b));

    always_ff @(posedge clk) begin
      if (we_b) begin
        words[wr_word] <= wr_data;
      end
    end

    assign bank_q[b] = words[rd_word];
  end

  always_comb begin
    rd_d = bank_q[rd_blk];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= rd_d;
      end
    end
  end

endmodule

// File: rtl/shram_guard.sv
module shram_guard
  import shram_pkg::*;
#(
  parameter  int NBLK   = 16,
  parameter  int WORDS  = 8,
  parameter  int DW     = 16,
  localparam int BLK_W  = $clog2(NBLK),
  localparam int WRD_W  = $clog2(WORDS),
  localparam int ADDR_W = BLK_W + WRD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_id,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              viol_valid,
  output logic [1:0]        viol_id,
  output logic [BLK_W-1:0]  viol_blk,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_id,
  input  logic [NBLK-1:0]   cfg_wdata,
  output logic              cfg_err,
  output logic [NBLK-1:0]   owner_map
);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  // Address split and owner lookup
  logic [BLK_W-1:0] req_blk;
  logic [WRD_W-1:0] req_word;
  logic             own_bit;
  logic             grant_c;
  logic             wr_c;
  logic             rd_c;
  logic             deny_c;
  src_t             req_src;

  always_comb begin
    req_blk  = req_addr[ADDR_W-1 -: BLK_W];
    req_word = req_addr[WRD_W-1:0];
    own_bit  = owner_map[req_blk];
    req_src  = src_t'(req_id);
  end

  shram_owner_reg #(.NBLK(NBLK)) u_owner (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cfg_we    (cfg_we),
    .cfg_id    (cfg_id),
    .cfg_wdata (cfg_wdata),
    .owner_map (owner_map),
    .cfg_err   (cfg_err)
  );

  shram_perm u_perm (
    .kind  (req_kind),
    .src   (req_src),
    .owner (own_bit),
    .grant (grant_c)
  );

  always_comb begin
    wr_c   = req_valid && grant_c && (req_kind == ACC_WRITE);
    rd_c   = req_valid && grant_c &&
             ((req_kind == ACC_READ) || (req_kind == ACC_FETCH));
    deny_c = req_valid && !grant_c;
  end

  // Response stage: next state, then registers
  logic             rsp_valid_d;
  logic             rsp_grant_d;
  logic             viol_d;
  logic             rd_en_q;
  logic [BLK_W-1:0] rd_blk_q;
  logic [WRD_W-1:0] rd_word_q;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_grant_d = req_valid && grant_c;
    viol_d      = deny_c;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      viol_valid <= 1'b0;
      viol_id    <= '0;
      viol_blk   <= '0;
      rd_en_q    <= 1'b0;
      rd_blk_q   <= '0;
      rd_word_q  <= '0;
    end else begin
      rsp_valid  <= rsp_valid_d;
      rsp_grant  <= rsp_grant_d;
      viol_valid <= viol_d;
      rd_en_q    <= rd_c;
      if (deny_c) begin
        viol_id  <= req_id;
        viol_blk <= req_blk;
      end
      if (rd_c) begin
        rd_blk_q  <= req_blk;
        rd_word_q <= req_word;
      end
    end
  end

  shram_mem #(.NBLK(NBLK), .WORDS(WORDS), .DW(DW)) u_mem (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (wr_c),
    .wr_blk   (req_blk),
    .wr_word  (req_word),
    .wr_data  (req_wdata),
    .rd_en    (rd_en_q),
    .rd_blk   (rd_blk_q),
    .rd_word  (rd_word_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/shram_guard_chk.sv
module shram_guard_chk #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_id,
  input logic [1:0]      req_kind,
  input logic            cfg_we,
  input logic [1:0]      cfg_id,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic            viol_valid,
  input logic            rd_valid,
  input logic            cfg_err,
  input logic [NBLK-1:0] owner_map
);

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R8

  AST_READ_ALWAYS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |=> rsp_grant); // R4

  AST_DMA_NEVER_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id[0] && req_kind == 2'd2) |=> !rsp_grant); // R3

  AST_VIOL_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (viol_valid == !rsp_grant)); // R10

  AST_VIOL_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> rsp_valid); // R10

  AST_NO_DATA_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |=> !rd_valid); // R9

  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_id == 2'd0) |=> $stable(owner_map)); // R5

  AST_CFG_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we && cfg_id != 2'd0)); // R6

  AST_CFG_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_id != 2'd0) |=> cfg_err); // R6

endmodule

bind shram_guard shram_guard_chk #(.NBLK(NBLK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_valid  (req_valid),
  .req_id     (req_id),
  .req_kind   (req_kind),
  .cfg_we     (cfg_we),
  .cfg_id     (cfg_id),
  .rsp_valid  (rsp_valid),
  .rsp_grant  (rsp_grant),
  .viol_valid (viol_valid),
  .rd_valid   (rd_valid),
  .cfg_err    (cfg_err),
  .owner_map  (owner_map)
);

// File: tb/tb_shram_guard.sv
`timescale 1ns/1ps
module tb_shram_guard;

  localparam int NBLK   = 16;
  localparam int WORDS  = 8;
  localparam int DW     = 16;
  localparam int BLK_W  = 4;
  localparam int WRD_W  = 3;
  localparam int ADDR_W = BLK_W + WRD_W;
  localparam int NWORDS = NBLK * WORDS;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_id;
  logic [1:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [DW-1:0]     req_wdata;
  logic              rsp_valid, rsp_grant, viol_valid, rd_valid, cfg_err;
  logic [1:0]        viol_id;
  logic [BLK_W-1:0]  viol_blk;
  logic [DW-1:0]     rd_data;
  logic              cfg_we;
  logic [1:0]        cfg_id;
  logic [NBLK-1:0]   cfg_wdata;
  logic [NBLK-1:0]   owner_map;

  always #4 clk = ~clk; // 125 MHz

  shram_guard #(.NBLK(NBLK), .WORDS(WORDS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
    .viol_valid(viol_valid), .viol_id(viol_id), .viol_blk(viol_blk),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .owner_map(owner_map)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    chk_on  = 1'b0;
  bit    done    = 1'b0;
  string phase   = "R1";

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL [%s] %s (phase %s): actual %0h expected %0h",
               tag, what, phase, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit [DW-1:0]    m_mem [NWORDS];
  bit [NBLK-1:0]  m_own;
  bit             m_rsp_v, m_grant, m_viol, m_rd_v, m_cfg_err, p_rd;
  bit [1:0]       m_vid;
  bit [BLK_W-1:0] m_vblk;
  bit [DW-1:0]    m_rd_d, p_rd_d;
  int             m_a, m_b;
  bit             m_ok;

  function automatic bit allowed(int id, int kind, bit owner_is_b);
    bit on_b  = (id >= 2);
    bit mine  = (on_b == owner_is_b);
    bit is_cpu = (id == 0) || (id == 2);
    if (kind == 0) return 1'b1;
    if (kind == 1) return mine;
    if (kind == 2) return mine && is_cpu;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = '0; m_rsp_v = 0; m_grant = 0; m_viol = 0;
      m_rd_v = 0; p_rd = 0; m_cfg_err = 0;
    end else begin
      m_rd_v = p_rd;
      if (p_rd) m_rd_d = p_rd_d;
      p_rd    = 1'b0;
      m_rsp_v = req_valid;
      m_grant = 1'b0;
      m_viol  = 1'b0;
      if (req_valid) begin
        m_a  = int'(req_addr);
        m_b  = m_a / WORDS;
        m_ok = allowed(int'(req_id), int'(req_kind), m_own[m_b]);
        m_grant = m_ok;
        m_viol  = !m_ok;
        if (!m_ok) begin
          m_vid  = req_id;
          m_vblk = m_b[BLK_W-1:0];
        end
        if (m_ok && req_kind == 2'd1) m_mem[m_a] = req_wdata;
        if (m_ok && (req_kind == 2'd0 || req_kind == 2'd2)) begin
          p_rd   = 1'b1;
          p_rd_d = m_mem[m_a];
        end
      end
      m_cfg_err = cfg_we && (cfg_id != 2'd0);
      if (cfg_we && cfg_id == 2'd0) m_own = cfg_wdata;
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk("R8",  "rsp_valid",  rsp_valid,  m_rsp_v);
      chk("R2",  "rsp_grant",  rsp_grant,  m_grant);   // R3 R4 via phase
      chk("R10", "viol_valid", viol_valid, m_viol);
      if (m_viol) begin
        chk("R10", "viol_id",  viol_id,  m_vid);
        chk("R10", "viol_blk", viol_blk, m_vblk);
      end
      chk("R9",  "rd_valid",   rd_valid,   m_rd_v);
      if (m_rd_v) chk("R9", "rd_data", rd_data, m_rd_d); // R7 R11 via phase
      chk("R6",  "cfg_err",    cfg_err,    m_cfg_err);
      chk("R5",  "owner_map",  owner_map,  m_own);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic acc(int id, int kind, int blk, int word, logic [DW-1:0] d);
    @(negedge clk);
    cfg_we    = 1'b0;
    req_valid = 1'b1;
    req_id    = id[1:0];
    req_kind  = kind[1:0];
    req_addr  = ADDR_W'(blk * WORDS + word);
    req_wdata = d;
  endtask

  task automatic cfg(int id, logic [NBLK-1:0] v);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_id    = id[1:0];
    cfg_wdata = v;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we    = 1'b0;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL [watchdog] run did not finish: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_kind = '0;
    req_addr = '0; req_wdata = '0; cfg_we = 1'b0; cfg_id = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R1";
    chk("R1", "owner_map after reset",  owner_map,  0);
    chk("R1", "rsp_valid after reset",  rsp_valid,  0);
    chk("R1", "rd_valid after reset",   rd_valid,   0);
    chk("R1", "viol_valid after reset", viol_valid, 0);
    chk("R1", "cfg_err after reset",    cfg_err,    0);
    chk_on = 1'b1;

    // Fill the whole memory as CPU A, which owns everything
    phase = "R11";
    for (int i = 0; i < NWORDS; i++) acc(0, 1, i / WORDS, i % WORDS, 16'h1000 + 16'(i));
    // First and last words of the outer blocks
    acc(0, 0, 0, 0, '0);
    acc(0, 0, 0, WORDS - 1, '0);
    acc(0, 0, NBLK - 1, 0, '0);
    acc(0, 0, NBLK - 1, WORDS - 1, '0);
    idle(3);

    phase = "R2";   // owning CPU: read, write, fetch
    acc(0, 1, 3, 2, 16'hA5A5);
    acc(0, 0, 3, 2, '0);
    acc(0, 2, 3, 2, '0);
    idle(3);

    phase = "R3";   // owning DMA: read/write yes, fetch no
    acc(1, 1, 3, 4, 16'h0D0D);
    acc(1, 0, 3, 4, '0);
    acc(1, 2, 3, 4, '0);
    idle(3);

    phase = "R4";   // non-owner side: reads only, reserved kind refused
    acc(2, 1, 3, 2, 16'hBAD0);
    acc(3, 1, 3, 2, 16'hBAD1);
    acc(2, 2, 5, 0, '0);
    acc(3, 2, 5, 0, '0);
    acc(2, 0, 5, 0, '0);
    acc(3, 0, 5, 1, '0);
    acc(0, 3, 5, 1, '0);
    idle(3);

    phase = "R7";   // refused writes above must not have landed
    acc(0, 0, 3, 2, '0);
    acc(3, 0, 3, 2, '0);
    idle(3);

    phase = "R6";   // owner vector writes from other IDs are dropped
    cfg(1, 16'hFFFF);
    cfg(2, 16'hFFFF);
    cfg(3, 16'h00F0);
    acc(2, 1, 4, 0, 16'h4444);  // still refused: side A owns block 4
    acc(0, 0, 4, 0, '0);
    idle(3);

    phase = "R5";   // hand blocks 3 and 15 to side B
    cfg(0, 16'h8008);
    acc(2, 1, 3, 1, 16'hB0B0);  // first cycle after the update: granted
    acc(2, 2, 3, 1, '0);
    acc(3, 2, 3, 1, '0);
    acc(0, 1, 3, 1, 16'hDEAD);
    acc(0, 2, 15, 7, '0);
    acc(1, 0, 15, 7, '0);
    acc(3, 1, 15, 7, 16'hF00F);
    acc(2, 0, 15, 7, '0);
    acc(0, 1, 2, 7, 16'h2222);  // neighbour still side A
    idle(3);
    cfg(0, 16'h0000);           // take everything back
    acc(2, 1, 3, 1, 16'h3333);
    acc(0, 1, 3, 1, 16'h3334);
    acc(0, 0, 3, 1, '0);
    idle(3);

    phase = "R8";   // random traffic, model compared every cycle
    for (int n = 0; n < 800; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        cfg(($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 3)) : 0,
            NBLK'($urandom));
      end else if ($urandom_range(0, 5) == 0) begin
        idle(1);
      end else begin
        acc(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, NBLK - 1)), int'($urandom_range(0, WORDS - 1)),
            DW'($urandom));
      end
    end
    idle(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule